// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

A synchronous static RAM with a parameterised array of words. Each word is split into independently writable byte lanes (four 9-bit lanes by default). Command and address are registered on one rising clock edge, and the data for that command moves in the following cycle. Read data flows straight from the array to `data_o` during that cycle. Write data is sampled on the edge that closes the cycle and then committed late, from a pending-write register. A bus master can therefore mix reads and writes on consecutive cycles with no idle cycle when the bus turns around.

A load command starts a four-beat burst, and every later non-load cycle advances a 2-bit beat counter. The beat order is either linear (wrapping add) or interleaved (XOR), chosen by a static input. The bidirectional data bus is split into `data_i`, `data_o` and `data_oe_o`. Three chip enables qualify new commands. A clock enable and a sleep input each freeze the whole block while keeping the array contents. An asynchronous output enable gates the bus drive.

Top module: `zbt_sram`

## Requirements
- R1: A read command registered on edge k (`load_n_i`=0, chip selected, `wr_n_i`=1) drives the word at `addr_i` on `data_o` with `data_oe_o`=1 during the cycle between edge k and edge k+1.
- R2: A write command registered on edge k stores the `data_i` value sampled on edge k+1 into the addressed word.
- R3: Reads and writes may follow each other on consecutive edges in any mix. A read registered on the edge right after a write to the same address returns the newly written lanes.
- R4: When `clk_en_n_i`=1 at an edge, every other synchronous input is ignored and all state and outputs hold as if that edge had not occurred.
- R5: The chip is selected only when `cs0_n_i`=0, `cs1_i`=1 and `cs2_n_i`=0. A load cycle with the chip deselected starts nothing, ends any burst and floats the bus in the next cycle. A data phase that is already pending still completes.
- R6: In the cycle after a write command is registered, `data_oe_o` is 0.
- R7: Bit i of `lane_we_n_i` (active low) enables writing of `data_i[9i+8:9i]`. It is sampled with the write command and again on every burst beat.
- R8: `lane_we_n_i` has no effect on read commands, and `data_i` is ignored in read and idle data phases.
- R9: `oe_n_i`=1 forces `data_oe_o` to 0 combinationally, with no clock edge needed.
- R10: Read data is flow-through: the value appears on `data_o` in the same cycle as its data phase, with no output register.
- R11: A cycle with `load_n_i`=1 advances an active burst. With base low bits a and beat c (0..3), the low two address bits are (a+c) mod 4 when `burst_ilv_i`=0 and a XOR c when `burst_ilv_i`=1. The upper address bits are unchanged.
- R12: While `sleep_i`=1, edges have no effect and array contents are kept.
- R13: After reset, `data_oe_o` is 0 and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_n_i | input | 1 | Active-low clock enable |
| sleep_i | input | 1 | Sleep: freezes the block, keeps the array |
| cs0_n_i | input | 1 | Chip enable, active low |
| cs1_i | input | 1 | Chip enable, active high |
| cs2_n_i | input | 1 | Chip enable, active low |
| load_n_i | input | 1 | 0: load a new command; 1: advance the burst |
| wr_n_i | input | 1 | 0: write, 1: read (on load cycles) |
| lane_we_n_i | input | LANES | Active-low per-lane write enables |
| addr_i | input | ADDR_W | Word address |
| burst_ilv_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| data_i | input | LANES*LANE_W | Write data from the bus |
| data_o | output | LANES*LANE_W | Read data to the bus |
| data_oe_o | output | 1 | Bus drive enable |

## Verification
Read results are due one edge after the command edge: the bench samples `data_o` and `data_oe_o` on the falling edge that follows that rising edge. A write becomes visible either through the bypass in the very next read phase or through the array in any later read. The bench therefore checks the written value by issuing reads one edge and several edges later. For the stall and sleep cases, results are sampled after each frozen edge and must equal the values sampled before that edge. The output-enable case is checked between edges, about 1 ns after `oe_n_i` changes.

// File: rtl/zbt_pkg.sv
package zbt_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/zbt_burst_seq.sv
module zbt_burst_seq #(
  parameter int BURST_BITS = 2
) (
  input  logic [BURST_BITS-1:0] base_i,
  input  logic [BURST_BITS-1:0] beat_i,
  input  logic                  ilv_i,
  output logic [BURST_BITS-1:0] addr_lo_o
);
  always_comb begin
    if (ilv_i) addr_lo_o = base_i ^ beat_i;
    else       addr_lo_o = base_i + beat_i;
  end
endmodule

// File: rtl/zbt_lane_array.sv
module zbt_lane_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES-1:0]        wbe_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk_i) begin
      if (we_i && !wbe_n_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zbt_late_write.sv
module zbt_late_write #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    capture_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_n_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic [LANES*LANE_W-1:0] arr_rdata_i,
  output logic                    commit_o,
  output logic [ADDR_W-1:0]       cm_addr_o,
  output logic [LANES-1:0]        cm_be_n_o,
  output logic [LANES*LANE_W-1:0] cm_data_o,
  output logic [LANES*LANE_W-1:0] rd_data_o
);
  logic                    pw_valid_q;
  logic [ADDR_W-1:0]       pw_addr_q;
  logic [LANES-1:0]        pw_be_n_q;
  logic [LANES*LANE_W-1:0] pw_data_q;
  logic                    hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pw_valid_q <= 1'b0;
      pw_addr_q  <= '0;
      pw_be_n_q  <= '1;
    end else if (en_i) begin
      pw_valid_q <= capture_i;
      pw_addr_q  <= addr_i;
      pw_be_n_q  <= be_n_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (en_i && capture_i) pw_data_q <= wdata_i;
  end

  // pending word retires on the next enabled edge
  assign commit_o  = en_i && pw_valid_q;
  assign cm_addr_o = pw_addr_q;
  assign cm_be_n_o = pw_be_n_q;
  assign cm_data_o = pw_data_q;

  assign hit = pw_valid_q && (rd_addr_i == pw_addr_q);

  for (genvar l = 0; l < LANES; l++) begin : g_byp
    assign rd_data_o[l*LANE_W +: LANE_W] = (hit && !pw_be_n_q[l])
                                          ? pw_data_q[l*LANE_W +: LANE_W]
                                          : arr_rdata_i[l*LANE_W +: LANE_W];
  end

  assert_pend_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pw_valid_q) && $stable(pw_addr_q) && $stable(pw_be_n_q));
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LANES      = 4,
  parameter int LANE_W     = 9,
  parameter int BURST_BITS = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_n_i,
  input  logic                    sleep_i,
  input  logic                    cs0_n_i,
  input  logic                    cs1_i,
  input  logic                    cs2_n_i,
  input  logic                    load_n_i,
  input  logic                    wr_n_i,
  input  logic [LANES-1:0]        lane_we_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    burst_ilv_i,
  input  logic                    oe_n_i,
  input  logic [LANES*LANE_W-1:0] data_i,
  output logic [LANES*LANE_W-1:0] data_o,
  output logic                    data_oe_o
);
  localparam int WORD_W = LANES * LANE_W;

  logic                  clk_en;
  logic                  sel;
  op_e                   op_q;
  logic [ADDR_W-1:0]     base_q;
  logic [BURST_BITS-1:0] beat_q;
  logic [LANES-1:0]      be_n_q;
  logic [BURST_BITS-1:0] addr_lo;
  logic [ADDR_W-1:0]     cur_addr;

  logic                  commit;
  logic [ADDR_W-1:0]     cm_addr;
  logic [LANES-1:0]      cm_be_n;
  logic [WORD_W-1:0]     cm_data;
  logic [WORD_W-1:0]     arr_rdata;
  logic [WORD_W-1:0]     rd_data;

  assign clk_en = !clk_en_n_i && !sleep_i;
  assign sel    = !cs0_n_i && cs1_i && !cs2_n_i;

  // command stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      beat_q <= '0;
      be_n_q <= '1;
    end else if (clk_en) begin
      if (!load_n_i) begin
        if (sel) begin
          op_q   <= wr_n_i ? OP_READ : OP_WRITE;
          base_q <= addr_i;
          beat_q <= '0;
          be_n_q <= wr_n_i ? '1 : lane_we_n_i;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        beat_q <= beat_q + BURST_BITS'(1);
        be_n_q <= (op_q == OP_WRITE) ? lane_we_n_i : '1;
      end
    end
  end

  zbt_burst_seq #(.BURST_BITS(BURST_BITS)) u_seq (
    .base_i   (base_q[BURST_BITS-1:0]),
    .beat_i   (beat_q),
    .ilv_i    (burst_ilv_i),
    .addr_lo_o(addr_lo)
  );

  assign cur_addr = {base_q[ADDR_W-1:BURST_BITS], addr_lo};

  zbt_late_write #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_lw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (clk_en),
    .capture_i  (op_q == OP_WRITE),
    .addr_i     (cur_addr),
    .be_n_i     (be_n_q),
    .wdata_i    (data_i),
    .rd_addr_i  (cur_addr),
    .arr_rdata_i(arr_rdata),
    .commit_o   (commit),
    .cm_addr_o  (cm_addr),
    .cm_be_n_o  (cm_be_n),
    .cm_data_o  (cm_data),
    .rd_data_o  (rd_data)
  );

  zbt_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk_i  (clk_i),
    .we_i   (commit),
    .waddr_i(cm_addr),
    .wbe_n_i(cm_be_n),
    .wdata_i(cm_data),
    .raddr_i(cur_addr),
    .rdata_o(arr_rdata)
  );

  // flow-through read path
  assign data_o    = rd_data;
  assign data_oe_o = (op_q == OP_READ) && !oe_n_i;

  assert_stall_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_n_i |=> $stable(op_q) && $stable(base_q) && $stable(beat_q));

  assert_sleep_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(op_q) && $stable(beat_q) && $stable(be_n_q));

  assert_desel_float_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en && !load_n_i && !sel) |=> !data_oe_o);

  assert_write_float_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en && !load_n_i && sel && !wr_n_i) |=> !data_oe_o);

  assert_oe_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !data_oe_o);
endmodule

// File: tb/zbt_sram_tb.sv
module zbt_sram_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_n = 1'b0;
  logic        sleep = 1'b0;
  logic        cs0_n = 1'b1;
  logic        cs1 = 1'b0;
  logic        cs2_n = 1'b1;
  logic        load_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [3:0]  lane_we_n = 4'hF;
  logic [7:0]  addr = '0;
  logic        ilv = 1'b0;
  logic        oe_n = 1'b0;
  logic [35:0] din = '0;
  logic [35:0] dout;
  logic        doe;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  zbt_sram u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clk_en_n_i(clk_en_n), .sleep_i(sleep),
    .cs0_n_i(cs0_n), .cs1_i(cs1), .cs2_n_i(cs2_n), .load_n_i(load_n),
    .wr_n_i(wr_n), .lane_we_n_i(lane_we_n), .addr_i(addr),
    .burst_ilv_i(ilv), .oe_n_i(oe_n), .data_i(din), .data_o(dout),
    .data_oe_o(doe)
  );

  localparam logic [35:0] D10  = 36'h1_2345_6789;
  localparam logic [35:0] D11  = 36'h9_8765_4321;
  localparam logic [35:0] D11M = 36'h9_8765_43FF;

  typedef struct packed {
    logic        ld_n;
    logic        wr_n;
    logic        sel;
    logic [7:0]  a;
    logic [3:0]  be_n;
    logic [35:0] d;
    logic        exp_oe;
    logic [35:0] exp_d;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 1'b1, 8'h10, 4'h0, 36'h0,           1'b0, 36'h0}, // R6 write cmd
    '{1'b0, 1'b0, 1'b1, 8'h11, 4'h0, D10,             1'b0, 36'h0}, // R2 R3 write after write
    '{1'b0, 1'b1, 1'b1, 8'h10, 4'hF, D11,             1'b1, D10},   // R1 R3 read after write
    '{1'b0, 1'b1, 1'b1, 8'h11, 4'hF, 36'h0,           1'b1, D11},   // R10
    '{1'b0, 1'b0, 1'b1, 8'h11, 4'hE, 36'h0,           1'b0, 36'h0}, // R7 lane 0 only
    '{1'b0, 1'b1, 1'b1, 8'h11, 4'hF, 36'hF_FFFF_FFFF, 1'b1, D11M},  // R3 bypass, R7
    '{1'b0, 1'b1, 1'b1, 8'h10, 4'h0, 36'hA_AAAA_AAAA, 1'b1, D10},   // R8
    '{1'b0, 1'b0, 1'b0, 8'h10, 4'h0, 36'h5_5555_5555, 1'b0, 36'h0}, // R5 deselect
    '{1'b0, 1'b1, 1'b1, 8'h11, 4'hF, 36'h0,           1'b1, D11M},  // R7
    '{1'b0, 1'b1, 1'b1, 8'h10, 4'hF, 36'h0,           1'b1, D10}    // R8 R5 nothing stray
  };

  task automatic cmd(input logic ld_n, input logic w_n, input logic s,
                     input logic [7:0] a, input logic [3:0] be, input logic [35:0] d);
    load_n = ld_n; wr_n = w_n; addr = a; lane_we_n = be; din = d;
    cs0_n = !s; cs1 = s; cs2_n = !s;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic e_oe, input logic [35:0] e_d);
    n_tests++;
    if (doe !== e_oe || (e_oe && dout !== e_d)) begin
      n_fail++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", req, doe, dout, e_oe, e_d);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [35:0] e, input string req);
    cmd(1'b0, 1'b1, 1'b1, a, 4'hF, 36'h0);
    cyc();
    chk(req, 1'b1, e);
  endtask

  localparam logic [35:0] B0 = 36'h8_0400_2000;
  localparam logic [35:0] B1 = 36'h8_0400_2001;
  localparam logic [35:0] B2 = 36'h8_0400_2002;
  localparam logic [35:0] B3 = 36'h8_0400_2003;
  localparam logic [35:0] B2M = 36'h0_0000_2002;

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 reset oe", 1'b0, 36'h0);
    rst_ni = 1'b1;
    cmd(1'b0, 1'b0, 1'b0, 8'h00, 4'hF, 36'h0);
    cyc();
    chk("R13 idle after reset", 1'b0, 36'h0);
    rd(8'h00, 36'h0, "R13 array zero");

    // vector table
    cmd(VEC[0].ld_n, VEC[0].wr_n, VEC[0].sel, VEC[0].a, VEC[0].be_n, VEC[0].d);
    for (int i = 0; i < NV; i++) begin
      cyc();
      chk($sformatf("table row %0d (R1 R2 R3 R5 R6 R7 R8 R10)", i), VEC[i].exp_oe, VEC[i].exp_d);
      if (i + 1 < NV)
        cmd(VEC[i+1].ld_n, VEC[i+1].wr_n, VEC[i+1].sel, VEC[i+1].a, VEC[i+1].be_n, VEC[i+1].d);
    end

    // R9 asynchronous output enable
    rd(8'h10, D10, "R9 read before oe");
    oe_n = 1'b1; #1;
    chk("R9 oe high floats", 1'b0, 36'h0);
    oe_n = 1'b0; #1;
    chk("R9 oe low drives", 1'b1, D10);

    // R4 stall during read phase
    clk_en_n = 1'b1;
    cmd(1'b0, 1'b1, 1'b1, 8'h11, 4'hF, 36'h0);
    cyc();
    chk("R4 stall holds read", 1'b1, D10);
    clk_en_n = 1'b0;
    // R4 stall during write phase
    cmd(1'b0, 1'b0, 1'b1, 8'h20, 4'h0, 36'h0);
    cyc();
    clk_en_n = 1'b1;
    cmd(1'b0, 1'b0, 1'b1, 8'h21, 4'h0, 36'h3_3333_3333);
    cyc();
    clk_en_n = 1'b0;
    cmd(1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h7_0000_0007);
    cyc();
    rd(8'h20, 36'h7_0000_0007, "R4 stalled edge did not capture data");
    rd(8'h21, 36'h0, "R4 stalled command ignored");

    // R12 sleep
    rd(8'h11, D11M, "R12 read before sleep");
    sleep = 1'b1;
    cmd(1'b0, 1'b0, 1'b1, 8'h11, 4'h0, 36'h0);
    cyc();
    chk("R12 sleep holds 1", 1'b1, D11M);
    din = 36'h6_6666_6666;
    cyc();
    chk("R12 sleep holds 2", 1'b1, D11M);
    sleep = 1'b0;
    cmd(1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h0);
    cyc();
    rd(8'h11, D11M, "R12 contents kept");

    // R5 each enable alone deselects
    for (int k = 0; k < 3; k++) begin
      cmd(1'b0, 1'b1, 1'b1, 8'h10, 4'hF, 36'h0);
      if (k == 0) cs0_n = 1'b1;
      if (k == 1) cs1 = 1'b0;
      if (k == 2) cs2_n = 1'b1;
      cyc();
      chk($sformatf("R5 enable %0d false", k), 1'b0, 36'h0);
    end
    // R5 pending write completes across deselect
    cmd(1'b0, 1'b0, 1'b1, 8'h30, 4'h0, 36'h0);
    cyc();
    cmd(1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 36'h0_DEAD_BEEF);
    cyc();
    chk("R5 deselect floats", 1'b0, 36'h0);
    rd(8'h30, 36'h0_DEAD_BEEF, "R5 pending write completed");

    // R11 linear burst write from 0x41, R7 per-beat lane enables
    ilv = 1'b0;
    cmd(1'b0, 1'b0, 1'b1, 8'h41, 4'h0, 36'h0);
    cyc();
    cmd(1'b1, 1'b1, 1'b1, 8'hFF, 4'h0, B0);
    cyc();
    cmd(1'b1, 1'b1, 1'b1, 8'hFF, 4'hC, B1);
    cyc();
    cmd(1'b1, 1'b1, 1'b1, 8'hFF, 4'h0, B2);
    cyc();
    cmd(1'b0, 1'b1, 1'b0, 8'h00, 4'hF, B3);
    cyc();
    rd(8'h40, B3, "R11 linear beat 3 wraps");
    rd(8'h41, B0, "R11 linear beat 0");
    rd(8'h42, B1, "R11 linear beat 1");
    rd(8'h43, B2M, "R7 burst beat lane enables");

    // R11 interleaved read burst from 0x42
    ilv = 1'b1;
    rd(8'h42, B1, "R11 ilv beat 0");
    cmd(1'b1, 1'b1, 1'b1, 8'h00, 4'hF, 36'h0);
    cyc(); chk("R11 ilv beat 1", 1'b1, B2M);
    cyc(); chk("R11 ilv beat 2", 1'b1, B3);
    cyc(); chk("R11 ilv beat 3", 1'b1, B0);

    // R11 linear read burst from 0x43
    ilv = 1'b0;
    rd(8'h43, B2M, "R11 lin read beat 0");
    cmd(1'b1, 1'b1, 1'b1, 8'h00, 4'hF, 36'h0);
    cyc(); chk("R11 lin read beat 1", 1'b1, B3);
    cyc(); chk("R11 lin read beat 2", 1'b1, B0);
    cyc(); chk("R11 lin read beat 3", 1'b1, B1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule